// File: doc/BRIEF.md
# Ordered-Load Accumulator ALU

This block is an 8-bit arithmetic and logic unit whose two operands reach it over a single shared load port, one word per cycle. An internal order pointer sends the first word to operand A and the next one to operand B. The pointer returns to A after every result, so which value is the minuend or the left-hand input depends only on the order in which the words were loaded. The result is registered and driven out with a one-cycle valid pulse, along with a carry flag and a zero flag.

Every function is built from four primitive outputs: a sum, XOR, OR and NOR. Each operand passes through its own controllable inverter on the way in. A 4-bit opcode, carried in the low bits of a 5-bit instruction word whose top bit marks it as an ALU operation, is expanded through a lookup into a 5-bit control word `{inv_a, inv_b, cin, sel[1:0]}`. For the sum, `inv_b` forces the B input to zero and `cin` is the carry-in. For the three logic selects, `cin` forces the B input to zero.

A result can be written back into operand A. In that case the pointer moves to B, so a chain of operations needs only one new load per step.

Top module: `seq_alu`

## Requirements
- R1: While reset is low, and in the first cycle after it, `res_valid`, `res_data`, `res_carry`, `res_zero` and `next_b` are all 0.
- R2: A load with no operation in the same cycle fills A when `next_b` is 0 and then sets `next_b`. When `next_b` is 1 it fills B and clears `next_b`.
- R3: An operation fires only when `op_valid` is 1 and `instr[4]` is 1. The result appears one cycle later with `res_valid` high for exactly one cycle. An instruction with `instr[4]`=0 gives no result and leaves A, B and `next_b` unchanged.
- R4: Arithmetic opcodes (`instr[3:0]`) are: 0 A+B, 1 B−A, 2 A+1, 10 pass A, 11 −A, 12 A+B+1. `res_carry` is bit 8 of the 9-bit sum, so B−A gives carry 1 exactly when B ≥ A.
- R5: Logic opcodes are: 4 A AND B, 5 OR, 6 XOR, 7 NOR, 8 NAND, 9 XNOR, 13 A AND NOT B, 14 A OR NOT B, 15 NOT A AND B. All of them give `res_carry` = 0.
- R6: Opcode 3 gives NOT A, whatever value B holds.
- R7: `res_zero` is 1 exactly when the registered result is 0.
- R8: An operation with `wb_a`=1 stores its result into A and sets `next_b` to 1.
- R9: An operation with `wb_a`=0 clears `next_b` and leaves A and B unchanged.
- R10: An operation issued with no new B loaded since the last result uses the B value that is retained.
- R11: A load presented in the same cycle as a firing operation is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load strobe for the shared operand port |
| ld_data | input | 8 | Operand word |
| op_valid | input | 1 | Instruction strobe |
| instr | input | 5 | Bit 4 marks an ALU operation; bits 3:0 are the opcode |
| wb_a | input | 1 | Write the result back into operand A |
| next_b | output | 1 | Order pointer: 1 when the next load fills B |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 8 | Registered result |
| res_carry | output | 1 | Carry out of the sum path, 0 for logic |
| res_zero | output | 1 | Result equals zero |

## Verification
All sixteen opcodes are run against six operand pairs. The pairs are equal values, zeros, all-ones plus one, complementary patterns, and the same two values swapped. The swap separates B−A from A−B. The all-ones pair separates carry from the zero flag, and the complementary pair separates AND, NAND and XNOR from their mirrored forms. NOT A is also run against two different B values. Separate sequences cover write-back chaining, an operation issued with only A reloaded, a load that collides with an operation, and an instruction with the ALU marker bit clear.

// File: rtl/seq_alu.sv
module seq_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_valid,
  input  logic [W-1:0] ld_data,
  input  logic         op_valid,
  input  logic [4:0]   instr,
  input  logic         wb_a,
  output logic         next_b,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         res_carry,
  output logic         res_zero
);
  localparam logic [1:0] S_SUM = 2'd0, S_XOR = 2'd1, S_OR = 2'd2, S_NOR = 2'd3;

  logic [W-1:0] a_q, b_q;
  logic [4:0]   ctl;

  always_comb begin
    case (instr[3:0])
      4'd0:    ctl = {3'b000, S_SUM};
      4'd1:    ctl = {3'b101, S_SUM};
      4'd2:    ctl = {3'b011, S_SUM};
      4'd3:    ctl = {3'b101, S_OR};
      4'd4:    ctl = {3'b110, S_NOR};
      4'd5:    ctl = {3'b000, S_OR};
      4'd6:    ctl = {3'b000, S_XOR};
      4'd7:    ctl = {3'b000, S_NOR};
      4'd8:    ctl = {3'b110, S_OR};
      4'd9:    ctl = {3'b100, S_XOR};
      4'd10:   ctl = {3'b010, S_SUM};
      4'd11:   ctl = {3'b111, S_SUM};
      4'd12:   ctl = {3'b001, S_SUM};
      4'd13:   ctl = {3'b100, S_NOR};
      4'd14:   ctl = {3'b010, S_OR};
      default: ctl = {3'b010, S_NOR};
    endcase
  end

  wire       inv_a = ctl[4];
  wire       inv_b = ctl[3];
  wire       cin   = ctl[2];
  wire [1:0] sel   = ctl[1:0];
  wire       fire  = op_valid & instr[4];

  wire [W-1:0] opa = inv_a ? ~a_q : a_q;
  wire [W-1:0] opb = (sel == S_SUM) ? (inv_b ? '0 : b_q)
                                    : (cin ? '0 : (inv_b ? ~b_q : b_q));
  wire [W:0]   sum = {1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cin & (sel == S_SUM)};

  logic [W-1:0] rslt;
  always_comb begin
    case (sel)
      S_SUM:   rslt = sum[W-1:0];
      S_XOR:   rslt = opa ^ opb;
      S_OR:    rslt = opa | opb;
      default: rslt = ~(opa | opb);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q       <= '0;
      b_q       <= '0;
      next_b    <= 1'b0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_carry <= 1'b0;
      res_zero  <= 1'b0;
    end else begin
      res_valid <= fire;
      if (fire) begin
        res_data  <= rslt;
        res_carry <= (sel == S_SUM) & sum[W];
        res_zero  <= (rslt == '0);
        next_b    <= wb_a;
        if (wb_a) a_q <= rslt;
      end else if (ld_valid) begin
        if (next_b) b_q <= ld_data;
        else        a_q <= ld_data;
        next_b <= ~next_b;
      end
    end
  end
endmodule

// File: rtl/seq_alu_chk.sv
module seq_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ld_valid,
  input logic         op_valid,
  input logic [4:0]   instr,
  input logic         wb_a,
  input logic         next_b,
  input logic         res_valid,
  input logic [W-1:0] res_data,
  input logic         res_zero
);
  wire fire = op_valid & instr[4];

  AST_VALID_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(fire)); // R3
  AST_NO_OP_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !res_valid); // R3
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_zero == (res_data == '0))); // R7
  AST_LOAD_A_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !fire && !next_b) |=> next_b); // R2
  AST_LOAD_B_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !fire && next_b) |=> !next_b); // R2
  AST_WB_POINTS_B: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wb_a) |=> next_b); // R8
  AST_RESULT_POINTS_A: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wb_a) |=> !next_b); // R9
  AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !ld_valid) |=> $stable(next_b)); // R3
endmodule

bind seq_alu seq_alu_chk #(.W(W)) u_seq_alu_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .op_valid(op_valid),
  .instr(instr), .wb_a(wb_a), .next_b(next_b), .res_valid(res_valid),
  .res_data(res_data), .res_zero(res_zero)
);

// File: tb/seq_alu_bench.sv
module seq_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid = 1'b0;
  logic [7:0] ld_data = '0;
  logic       op_valid = 1'b0;
  logic [4:0] instr = '0;
  logic       wb_a = 1'b0;
  logic       next_b;
  logic       res_valid;
  logic [7:0] res_data;
  logic       res_carry;
  logic       res_zero;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] data;
    logic       carry;
    logic       zero;
    string      req;
  } exp_t;
  exp_t sb[$];

  logic [7:0] m_a = '0, m_b = '0;
  logic       m_ptr = 1'b0;

  always #10 clk = ~clk;

  seq_alu u_seq_alu (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data),
    .op_valid(op_valid), .instr(instr), .wb_a(wb_a), .next_b(next_b),
    .res_valid(res_valid), .res_data(res_data), .res_carry(res_carry),
    .res_zero(res_zero)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    case (op)
      4'd0:  return {1'b0, a} + {1'b0, b};
      4'd1:  return {(b >= a), b - a};
      4'd2:  return {1'b0, a} + 9'd1;
      4'd3:  return {1'b0, ~a};
      4'd4:  return {1'b0, a & b};
      4'd5:  return {1'b0, a | b};
      4'd6:  return {1'b0, a ^ b};
      4'd7:  return {1'b0, ~(a | b)};
      4'd8:  return {1'b0, ~(a & b)};
      4'd9:  return {1'b0, ~(a ^ b)};
      4'd10: return {1'b0, a};
      4'd11: return {(a == 8'd0), 8'd0 - a};
      4'd12: return {1'b0, a} + {1'b0, b} + 9'd1;
      4'd13: return {1'b0, a & ~b};
      4'd14: return {1'b0, a | ~b};
      default: return {1'b0, ~a & b};
    endcase
  endfunction

  // R2: order pointer decides A then B
  task automatic load(input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_data = d;
    if (m_ptr) m_b = d; else m_a = d;
    m_ptr = ~m_ptr;
    @(negedge clk);
    ld_valid = 1'b0;
    check("R2 pointer after load", {15'd0, next_b}, {15'd0, m_ptr});
  endtask

  task automatic op(input logic [3:0] code, input logic wb, input logic with_ld, input string req);
    logic [8:0] r;
    exp_t e;
    @(negedge clk);
    op_valid = 1'b1; instr = {1'b1, code}; wb_a = wb;
    ld_valid = with_ld; ld_data = 8'hE7;   // R11: load must be dropped
    r = model(code, m_a, m_b);
    e.data = r[7:0]; e.carry = r[8]; e.zero = (r[7:0] == 8'd0); e.req = req;
    sb.push_back(e);
    if (wb) m_a = r[7:0];
    m_ptr = wb;
    @(negedge clk);
    op_valid = 1'b0; wb_a = 1'b0; ld_valid = 1'b0;
    check({req, " pointer after result"}, {15'd0, next_b}, {15'd0, m_ptr}); // R8 R9
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R3 unexpected result act=%h exp=none", res_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " data"}, {8'd0, res_data}, {8'd0, e.data});
        check({e.req, " carry"}, {15'd0, res_carry}, {15'd0, e.carry});
        check({e.req, " R7 zero"}, {15'd0, res_zero}, {15'd0, e.zero});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] pa [6] = '{8'h3C, 8'h05, 8'hFF, 8'h00, 8'hA5, 8'h80};
    logic [7:0] pb [6] = '{8'h05, 8'h3C, 8'h01, 8'h00, 8'h5A, 8'h80};
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", {15'd0, res_valid}, 16'd0);
    check("R1 data in reset", {8'd0, res_data}, 16'd0);
    check("R1 flags in reset", {14'd0, res_carry, res_zero}, 16'd0);
    check("R1 pointer in reset", {15'd0, next_b}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {15'd0, res_valid}, 16'd0);
    check("R1 pointer after reset", {15'd0, next_b}, 16'd0);

    // R4 R5 R6 R7 R10: every opcode over several operand pairs, B retained across ops
    for (int p = 0; p < 6; p++) begin
      load(pa[p]);
      load(pb[p]);
      for (int c = 0; c < 16; c++)
        op(c[3:0], 1'b0, 1'b0, (c inside {0, 1, 2, 10, 11, 12}) ? "R4" : (c == 3) ? "R6" : "R5");
    end

    // R6: NOT A with two different B values
    load(8'h33); load(8'h00); op(4'd3, 1'b0, 1'b0, "R6");
    load(8'h33); load(8'hFF); op(4'd3, 1'b0, 1'b0, "R6");

    // R8: write-back chain
    load(8'h10); load(8'h03);
    op(4'd0, 1'b1, 1'b0, "R8");
    load(8'h07);
    op(4'd0, 1'b0, 1'b0, "R8");
    op(4'd10, 1'b0, 1'b0, "R8");

    // R10: reload only A, B retained
    load(8'h21);
    op(4'd1, 1'b0, 1'b0, "R10");

    // R11: load colliding with an operation is dropped
    op(4'd0, 1'b0, 1'b1, "R11");
    op(4'd1, 1'b0, 1'b0, "R11");

    // R3: instruction without the ALU marker bit
    @(negedge clk);
    op_valid = 1'b1; instr = 5'b0_0000;
    @(negedge clk);
    op_valid = 1'b0;
    check("R3 no result without marker", {15'd0, res_valid}, 16'd0);
    check("R3 pointer held", {15'd0, next_b}, {15'd0, m_ptr});
    op(4'd0, 1'b0, 1'b0, "R3");

    repeat (3) @(negedge clk);
    check("R3 scoreboard drained", sb.size(), 16'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule